// File: doc/BRIEF.md
# Transmit Gating and Tristate Serializer

This block takes one 4-bit write-enable word per serial frame, in the fast PLL clock domain, and turns it into two per-slice serial control streams for up to six lane slices. The first is a transmit gate stream: each used enable bit is repeated over two unit intervals (UI), least significant bit first, and passes data where it is 1 and blocks data where it is 0. The second is the tristate control: for each slice a select chooses between a combinational tristate input and the inverted, serialized enable. The inverted enable is aligned to the transmitted data, so an enable of 0 puts the buffer in high impedance for exactly those UIs.

One clock cycle is one UI. A frame is 2, 4 or 8 UIs long, chosen by the width input. A frame marker output is high in the first UI of each frame. The enable word is sampled on the clock edge that ends the last UI of a frame, and it governs the whole of the next frame. One slice is built as ungateable and always passes data. Width/mode combinations that cannot be supported raise a configuration error. While the error is raised, the block falls back to a safe setting: gating is off and every slice takes its tristate from the combinational input.

Top module: `tx_gate_tristate_ser`

## Requirements
- R1: While reset is low and right after it is released, `frame_o` is 1, every gated slice shows `gate_o` 0 and every slice that selects the enable source shows `t_out_o` 1 (tristated). These are the values for an all-zero enable word.
- R2: A slice whose `tsel_i` bit is 0 drives `t_out_o[x]` equal to `t_i[x]` in the same cycle, with no register on the path.
- R3: A slice whose `tsel_i` bit is 1 (with no configuration error) drives `t_out_o[x]` with the inverse of the serialized enable bit for the current UI. An enable of 0 gives 1 (high impedance).
- R4: With `gate_en_i` = 1, `gate_o[x]` of a gated slice equals the serialized enable bit, not inverted. With `gate_en_i` = 0, all `gate_o` bits are 1.
- R5: Slice index UNGATED_SLICE (default 1) always has `gate_o` = 1, whatever the enable word and `gate_en_i`.
- R6: Width code 2'b10 (8 UIs): enable bit `k/2` controls UI k for k = 0..7, so each bit covers two UIs, bit 0 first.
- R7: Width code 2'b01 (4 UIs): UIs 0 and 1 use enable bit 0, and UIs 2 and 3 use enable bit 2. Bits 1 and 3 have no effect.
- R8: Width code 2'b00 (2 UIs): frames last two cycles. With gating disabled and all `tsel_i` bits 0 the setting is legal: `cfg_err_o` = 0 and all `gate_o` bits are 1.
- R9: `cfg_err_o` is 1 exactly when the width code is the reserved 2'b11, or when the width code is 2'b00 with `gate_en_i` = 1 or any `tsel_i` bit set.
- R10: While `cfg_err_o` = 1, all `gate_o` bits are 1 and `t_out_o` equals `t_i` for every slice.
- R11: `frame_o` is 1 in UI 0 of each frame only. The enable word present on the clock edge that ends a frame's last UI controls every UI of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PLL clock, one UI per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wren_i | input | 4 | Write-enable word, sampled once per frame |
| t_i | input | 6 | Combinational tristate input per slice |
| tsel_i | input | 6 | Tristate source per slice: 0 = t_i, 1 = inverted enable |
| gate_en_i | input | 1 | Transmit gating enable |
| width_i | input | 2 | Frame width: 00 = 2, 01 = 4, 10 = 8, 11 reserved |
| gate_o | output | 6 | Serial transmit gate per slice, 1 = pass |
| t_out_o | output | 6 | Tristate control per slice, 1 = high impedance |
| frame_o | output | 1 | High in the first UI of each frame |
| cfg_err_o | output | 1 | Illegal width/mode combination |

## Verification
Gating and tristating both draw on the same serialized enable bit in the same UI. A slice with its enable-source select set therefore shows `gate_o` and `t_out_o` as complements of each other in every UI, while the ungateable slice keeps passing data. The bench runs frames with gating enabled and every slice on the enable source. It uses alternating and irregular enable patterns at both serial widths and compares both outputs of all six slices in each UI against values computed from the word it drove. Mixed selects are also exercised, so that the combinational tristate and the serialized tristate appear side by side in one cycle. The fallback when the configuration turns illegal is judged on the same outputs.

// File: rtl/tgs_pkg.sv
package tgs_pkg;
  localparam int UI_W = 3;

  typedef enum logic [1:0] {
    WID_2   = 2'b00,
    WID_4   = 2'b01,
    WID_8   = 2'b10,
    WID_RSV = 2'b11
  } width_e;

  function automatic logic [UI_W-1:0] ui_last(width_e w);
    case (w)
      WID_2:   return UI_W'(1);
      WID_4:   return UI_W'(3);
      default: return UI_W'(7);
    endcase
  endfunction
endpackage

// File: rtl/tgs_ui_counter.sv
module tgs_ui_counter
  import tgs_pkg::*;
#(
  parameter int WREN_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  width_e            width_i,
  input  logic [WREN_W-1:0] wren_i,
  output logic [UI_W-1:0]   ui_o,
  output logic [WREN_W-1:0] word_o,
  output logic              frame_o
);
  logic [UI_W-1:0]   ui_q;
  logic [WREN_W-1:0] word_q;
  logic              wrap;

  // >= so a width shrink mid-frame wraps at once
  assign wrap = (ui_q >= ui_last(width_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ui_q   <= '0;
      word_q <= '0;
    end else if (wrap) begin
      ui_q   <= '0;
      word_q <= wren_i;
    end else begin
      ui_q   <= ui_q + UI_W'(1);
    end
  end

  assign ui_o    = ui_q;
  assign word_o  = word_q;
  assign frame_o = (ui_q == '0);
endmodule

// File: rtl/tgs_bit_map.sv
module tgs_bit_map
  import tgs_pkg::*;
#(
  parameter int WREN_W = 4,
  localparam int IDX_W = $clog2(WREN_W)
) (
  input  logic [WREN_W-1:0] word_i,
  input  logic [UI_W-1:0]   ui_i,
  input  width_e            width_i,
  output logic              bit_o
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    case (width_i)
      WID_8:   idx = IDX_W'(ui_i >> 1);
      WID_4:   idx = IDX_W'({ui_i[1], 1'b0});
      default: idx = '0;
    endcase
  end

  assign bit_o = word_i[idx];
endmodule

// File: rtl/tgs_cfg_check.sv
module tgs_cfg_check
  import tgs_pkg::*;
#(
  parameter int NUM_SLICES = 6
) (
  input  width_e                width_i,
  input  logic                  gate_en_i,
  input  logic [NUM_SLICES-1:0] tsel_i,
  output logic                  err_o
);
  assign err_o = (width_i == WID_RSV) ||
                 ((width_i == WID_2) && (gate_en_i || (|tsel_i)));
endmodule

// File: rtl/tgs_slice_ctrl.sv
module tgs_slice_ctrl #(
  parameter int SLICE_IDX     = 0,
  parameter int UNGATED_SLICE = 1
) (
  input  logic ser_bit_i,
  input  logic gate_en_i,
  input  logic tsel_i,
  input  logic t_i,
  output logic gate_o,
  output logic t_o
);
  if (SLICE_IDX == UNGATED_SLICE) begin : g_fixed
    assign gate_o = 1'b1;
  end else begin : g_gated
    assign gate_o = gate_en_i ? ser_bit_i : 1'b1;
  end

  // enable source is inverted: 0 -> high impedance
  assign t_o = tsel_i ? ~ser_bit_i : t_i;
endmodule

// File: rtl/tx_gate_tristate_ser.sv
module tx_gate_tristate_ser #(
  parameter int NUM_SLICES    = 6,
  parameter int WREN_W        = 4,
  parameter int UNGATED_SLICE = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [WREN_W-1:0]     wren_i,
  input  logic [NUM_SLICES-1:0] t_i,
  input  logic [NUM_SLICES-1:0] tsel_i,
  input  logic                  gate_en_i,
  input  logic [1:0]            width_i,
  output logic [NUM_SLICES-1:0] gate_o,
  output logic [NUM_SLICES-1:0] t_out_o,
  output logic                  frame_o,
  output logic                  cfg_err_o
);
  import tgs_pkg::*;

  width_e                width;
  logic [UI_W-1:0]       ui;
  logic [WREN_W-1:0]     word;
  logic                  ser_bit;
  logic                  cfg_err;
  logic                  gate_en_eff;
  logic [NUM_SLICES-1:0] tsel_eff;

  assign width = width_e'(width_i);

  tgs_ui_counter #(.WREN_W(WREN_W)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .width_i (width),
    .wren_i  (wren_i),
    .ui_o    (ui),
    .word_o  (word),
    .frame_o (frame_o)
  );

  tgs_bit_map #(.WREN_W(WREN_W)) i_map (
    .word_i  (word),
    .ui_i    (ui),
    .width_i (width),
    .bit_o   (ser_bit)
  );

  tgs_cfg_check #(.NUM_SLICES(NUM_SLICES)) i_cfg (
    .width_i   (width),
    .gate_en_i (gate_en_i),
    .tsel_i    (tsel_i),
    .err_o     (cfg_err)
  );

  // safe fallback on illegal setting
  assign gate_en_eff = gate_en_i & ~cfg_err;
  assign tsel_eff    = tsel_i & {NUM_SLICES{~cfg_err}};
  assign cfg_err_o   = cfg_err;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    tgs_slice_ctrl #(
      .SLICE_IDX     (s),
      .UNGATED_SLICE (UNGATED_SLICE)
    ) i_slice (
      .ser_bit_i (ser_bit),
      .gate_en_i (gate_en_eff),
      .tsel_i    (tsel_eff[s]),
      .t_i       (t_i[s]),
      .gate_o    (gate_o[s]),
      .t_o       (t_out_o[s])
    );
  end
endmodule

// File: rtl/tgs_checker.sv
module tgs_checker #(
  parameter int NUM_SLICES    = 6,
  parameter int UNGATED_SLICE = 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_SLICES-1:0] t_i,
  input logic [NUM_SLICES-1:0] tsel_i,
  input logic                  gate_en_i,
  input logic [1:0]            width_i,
  input logic [NUM_SLICES-1:0] gate_o,
  input logic [NUM_SLICES-1:0] t_out_o,
  input logic                  frame_o,
  input logic                  cfg_err_o
);
  AST_UNGATED_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o[UNGATED_SLICE]); // R5

  AST_ERR_T_FALLBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (t_out_o == t_i)); // R10

  AST_ERR_NO_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (&gate_o)); // R10

  AST_W2_GATE_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_i == 2'b00 && gate_en_i) |-> cfg_err_o); // R9

  AST_RSV_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_i == 2'b11) |-> cfg_err_o); // R9

  AST_NO_GATE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_en_i |-> (&gate_o)); // R4

  AST_FRAME_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_o && $stable(width_i)) |=> !frame_o); // R11

  AST_UI_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(frame_o) && $stable(width_i) && $stable(gate_en_i) && $stable(tsel_i))
      |-> $stable(gate_o)); // R6
endmodule

bind tx_gate_tristate_ser tgs_checker #(
  .NUM_SLICES    (NUM_SLICES),
  .UNGATED_SLICE (UNGATED_SLICE)
) i_tgs_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .t_i       (t_i),
  .tsel_i    (tsel_i),
  .gate_en_i (gate_en_i),
  .width_i   (width_i),
  .gate_o    (gate_o),
  .t_out_o   (t_out_o),
  .frame_o   (frame_o),
  .cfg_err_o (cfg_err_o)
);

// File: tb/test_tx_gate_tristate_ser.sv
`timescale 1ns/1ps
module test_tx_gate_tristate_ser;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] wren_i = '0;
  logic [5:0] t_i = '0;
  logic [5:0] tsel_i = '1;
  logic       gate_en_i = 1'b1;
  logic [1:0] width_i = 2'b10;
  logic [5:0] gate_o, t_out_o;
  logic       frame_o, cfg_err_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  tx_gate_tristate_ser i_tx_gate_tristate_ser (
    .clk_i, .rst_ni, .wren_i, .t_i, .tsel_i, .gate_en_i, .width_i,
    .gate_o, .t_out_o, .frame_o, .cfg_err_o
  );

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int frame_len(logic [1:0] w);
    return (w == 2'b00) ? 2 : (w == 2'b01) ? 4 : 8;
  endfunction

  function automatic bit legal(logic [1:0] w, logic ge, logic [5:0] ts);
    return !(w == 2'b11 || (w == 2'b00 && (ge || |ts)));
  endfunction

  function automatic logic ser_bit(logic [3:0] wd, logic [1:0] w, int k);
    if (w == 2'b10) return wd[k/2];
    if (w == 2'b01) return wd[(k/2)*2];
    return wd[0];
  endfunction

  task automatic sync_frame();
    @(negedge clk_i);
    while (!frame_o) @(negedge clk_i);
  endtask

  // load a word and check every UI of the frame it controls
  task automatic run_frame(string req, logic [3:0] wd);
    bit ok;
    logic [5:0] eg, et;
    logic b;
    int n;
    n = frame_len(width_i);
    ok = legal(width_i, gate_en_i, tsel_i);
    while (!frame_o) @(negedge clk_i);
    wren_i = wd;
    sync_frame();
    for (int k = 0; k < n; k++) begin
      b = ser_bit(wd, width_i, k);
      for (int x = 0; x < 6; x++) begin
        eg[x] = (ok && gate_en_i && x != 1) ? b : 1'b1;
        et[x] = (ok && tsel_i[x]) ? ~b : t_i[x];
      end
      chk({req, " R11 frame"}, 8'(frame_o), 8'(k == 0));
      chk({req, " R4 gate"}, 8'(gate_o), 8'(eg));
      chk({req, " R3 tout"}, 8'(t_out_o), 8'(et));
      chk({req, " R9 err"}, 8'(cfg_err_o), 8'(!ok));
      @(negedge clk_i);
    end
  endtask

  task automatic t_reset();
    #12;
    chk("R1 frame in reset", 8'(frame_o), 8'd1);
    chk("R1 gate in reset", 8'(gate_o), 8'b0000_0010);
    chk("R1 tout in reset", 8'(t_out_o), 8'b0011_1111);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R1 frame after reset", 8'(frame_o), 8'd1);
    chk("R5 gate after reset", 8'(gate_o), 8'b0000_0010);
  endtask

  task automatic t_width8();
    width_i = 2'b10; gate_en_i = 1'b1; tsel_i = '1;
    run_frame("R6 w8 a", 4'b1010);
    run_frame("R6 w8 b", 4'b0110);
    run_frame("R6 w8 c", 4'b1111);
    run_frame("R6 w8 d", 4'b0001);
  endtask

  task automatic t_width4();
    width_i = 2'b01;
    run_frame("R7 w4 settle", 4'b0101);
    run_frame("R7 w4 a", 4'b0101);
    run_frame("R7 w4 b", 4'b1010);
    run_frame("R7 w4 c", 4'b0100);
  endtask

  task automatic t_comb_t();
    width_i = 2'b10;
    tsel_i = 6'b001100;
    t_i = 6'b100001;
    run_frame("R2 mixed", 4'b0011);
    @(negedge clk_i);
    t_i = 6'b010010;
    #1;
    chk("R2 comb t", 8'(t_out_o & 6'b110011), 8'(6'b010010));
  endtask

  task automatic t_no_gate();
    gate_en_i = 1'b0;
    tsel_i = '1;
    run_frame("R4 gate off", 4'b0000);
    gate_en_i = 1'b1;
  endtask

  task automatic t_width2();
    width_i = 2'b00; gate_en_i = 1'b0; tsel_i = '0; t_i = 6'b110100;
    run_frame("R8 w2 settle", 4'b0000);
    run_frame("R8 w2", 4'b0000);
    chk("R8 err", 8'(cfg_err_o), 8'd0);
    chk("R8 all pass", 8'(gate_o), 8'b0011_1111);
  endtask

  task automatic t_errors();
    width_i = 2'b00; gate_en_i = 1'b1; tsel_i = '1; t_i = 6'b010101;
    #1;
    chk("R9 w2 gate", 8'(cfg_err_o), 8'd1);
    chk("R10 tout fallback", 8'(t_out_o), 8'(6'b010101));
    chk("R10 gate fallback", 8'(gate_o), 8'b0011_1111);
    gate_en_i = 1'b0; tsel_i = 6'b000100;
    #1;
    chk("R9 w2 tsel", 8'(cfg_err_o), 8'd1);
    tsel_i = '0;
    #1;
    chk("R9 w2 legal", 8'(cfg_err_o), 8'd0);
    width_i = 2'b11; gate_en_i = 1'b1; tsel_i = '1;
    run_frame("R10 reserved", 4'b0000);
    width_i = 2'b10;
    #1;
    chk("R9 back legal", 8'(cfg_err_o), 8'd0);
  endtask

  initial begin
    t_reset();
    t_width8();
    t_width4();
    t_comb_t();
    t_no_gate();
    t_width2();
    t_errors();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule